// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block sits on the host side of a parallel flash bus and decides when an embedded program or erase has finished. After a start pulse it reads the device's status byte in pairs and compares bit 6 of the two reads in each pair. While bit 6 changes from one read to the next, the device is still working. When bit 6 holds steady, the operation has ended. If bit 6 is still changing when the device's internal time-limit flag (bit 5) is set, the block takes one more pair of reads to confirm before it treats the operation as failed.

When the operation fails, the block sends one reset-command write so the device returns to normal array reads, and then pulses its fail output. A host-programmed cap on the number of polling pairs gives a second way to time out, independent of the device's own flag. The block does not issue the program or erase command sequences, and it does not handle bus AC timing. Reads use a one-cycle request and a returned byte qualified by a valid strobe.

Top module: `tgl_poll_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, busy_o, done_o, fail_o, rd_req_o and wr_req_o are all 0.
- R2: A start_i pulse while idle raises busy_o and rd_req_o in the next cycle. Each read request is high for exactly one cycle. The next request follows in the cycle after rd_valid_i returns the byte.
- R3: Reads come in pairs. If bit 6 of the second read equals bit 6 of the first, the block pulses done_o and makes no write. Bits other than 6 and 5 of the status byte have no effect.
- R4: If bit 6 differs between the two reads of a pair and bit 5 of the second read is 0, a new pair of reads begins. The number of reads issued equals twice the number of pairs evaluated.
- R5: If bit 6 differs and bit 5 of the second read is 1, exactly one confirming pair is read. If bit 6 is steady on that pair, the block pulses done_o.
- R6: If bit 6 still differs on the confirming pair, the block issues one write with wr_data_o = 8'hF0 and wr_addr_o = 0, lasting one cycle. fail_o pulses in the next cycle.
- R7: When max_polls_i (sampled at start) is nonzero, the pair that is the max_polls_i-th toggling pair with bit 5 clear ends the run through the R6 write-then-fail path. A value of 0 means no limit. A set bit 5 takes precedence over the limit, and confirming pairs are not counted.
- R8: done_o and fail_o are single-cycle pulses, are never high together, and busy_o is 0 in the cycle either one is high.
- R9: start_i is ignored while busy_o is high: it does not change the sequence or the count of reads.
- R10: rd_req_o and wr_req_o are never high in the same cycle, and neither is high while busy_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin polling (ignored while busy) |
| max_polls_i | input | CNT_W | Host limit on toggling pairs, 0 = no limit |
| rd_req_o | output | 1 | One-cycle status read request |
| rd_valid_i | input | 1 | Returned status byte is valid |
| rd_data_i | input | 8 | Returned status byte |
| wr_req_o | output | 1 | One-cycle reset-command write request |
| wr_addr_o | output | ADDR_W | Write address (always 0) |
| wr_data_o | output | 8 | Write data (8'hF0 during the write) |
| busy_o | output | 1 | Polling in progress |
| done_o | output | 1 | One-cycle pulse on successful completion |
| fail_o | output | 1 | One-cycle pulse after a failed operation |

## Verification
A stale first-read register or a wrong pair-phase bit changes which bytes are compared. Within the same run, this shows up as an early done_o or as extra read requests. A confirm flag that is not set, or not cleared at the next start, turns a confirming pair into another polling pair (or the reverse). The result is a done where a fail was expected, or a missing reset write, and the difference shows up two reads later. A mis-loaded poll limit moves the fail pulse by whole pairs, so the bench compares exact read counts for every run.

// File: rtl/tgl_poll_pkg.sv
package tgl_poll_pkg;

    localparam int STAT_W  = 8;
    localparam int TOG_BIT = 6;
    localparam int LIM_BIT = 5;
    localparam logic [STAT_W-1:0] RESET_CMD = 8'hF0;

    typedef logic [STAT_W-1:0] stat_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_WRITE
    } seq_state_e;

    typedef enum logic [1:0] {
        ACT_FINISHED,
        ACT_RETRY,
        ACT_CONFIRM,
        ACT_ABORT
    } action_e;

    typedef struct packed {
        logic toggled;
        logic limit_seen;
    } pair_verdict_t;

    function automatic pair_verdict_t judge_pair(input logic first_tog, input stat_t second);
        pair_verdict_t v;
        v.toggled    = first_tog ^ second[TOG_BIT];
        v.limit_seen = second[LIM_BIT];
        return v;
    endfunction

endpackage

// File: rtl/tgl_poll_eval.sv
module tgl_poll_eval
    import tgl_poll_pkg::*;
(
    input  logic    first_tog_i,
    input  stat_t   second_i,
    input  logic    confirm_i,
    input  logic    limit_last_i,
    output action_e action_o
);

    pair_verdict_t verdict;
    logic          unused_bits;

    assign verdict     = judge_pair(first_tog_i, second_i);
    assign unused_bits = ^{second_i[STAT_W-1], second_i[LIM_BIT-1:0]};

    always_comb begin
        if (!verdict.toggled)
            action_o = ACT_FINISHED;
        else if (confirm_i)
            action_o = ACT_ABORT;
        else if (verdict.limit_seen)
            action_o = ACT_CONFIRM;
        else if (limit_last_i)
            action_o = ACT_ABORT;
        else
            action_o = ACT_RETRY;
    end

endmodule

// File: rtl/tgl_poll_limit.sv
module tgl_poll_limit #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] max_i,
    input  logic             inc_i,
    output logic             last_o
);

    logic [CNT_W-1:0] limit_q;
    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            limit_q <= '0;
            count_q <= '0;
        end else if (load_i) begin
            limit_q <= max_i;
            count_q <= '0;
        end else if (inc_i) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign last_o = (limit_q != '0) && (count_q == limit_q - 1'b1);

endmodule

// File: rtl/tgl_poll_seq.sv
module tgl_poll_seq
    import tgl_poll_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start_i,
    input  logic    rd_valid_i,
    input  stat_t   rd_data_i,
    input  action_e action_i,
    output logic    first_tog_o,
    output logic    confirm_o,
    output logic    load_o,
    output logic    inc_o,
    output logic    rd_req_o,
    output logic    wr_req_o,
    output logic    busy_o,
    output logic    done_o,
    output logic    fail_o
);

    seq_state_e st_q;
    logic       second_q;
    logic       confirm_q;
    logic       first_tog_q;
    logic       done_q;
    logic       fail_q;
    logic       pair_end;

    assign pair_end = (st_q == ST_WAIT) && rd_valid_i && second_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            second_q    <= 1'b0;
            confirm_q   <= 1'b0;
            first_tog_q <= 1'b0;
            done_q      <= 1'b0;
            fail_q      <= 1'b0;
        end else begin
            done_q <= 1'b0;
            fail_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        st_q      <= ST_ISSUE;
                        second_q  <= 1'b0;
                        confirm_q <= 1'b0;
                    end
                end
                ST_ISSUE: st_q <= ST_WAIT;
                ST_WAIT: begin
                    if (rd_valid_i) begin
                        if (!second_q) begin
                            first_tog_q <= rd_data_i[TOG_BIT];
                            second_q    <= 1'b1;
                            st_q        <= ST_ISSUE;
                        end else begin
                            second_q <= 1'b0;
                            case (action_i)
                                ACT_FINISHED: begin
                                    st_q   <= ST_IDLE;
                                    done_q <= 1'b1;
                                end
                                ACT_RETRY: st_q <= ST_ISSUE;
                                ACT_CONFIRM: begin
                                    confirm_q <= 1'b1;
                                    st_q      <= ST_ISSUE;
                                end
                                default: st_q <= ST_WRITE;
                            endcase
                        end
                    end
                end
                default: begin
                    st_q   <= ST_IDLE;
                    fail_q <= 1'b1;
                end
            endcase
        end
    end

    assign first_tog_o = first_tog_q;
    assign confirm_o   = confirm_q;
    assign load_o      = (st_q == ST_IDLE) && start_i;
    assign inc_o       = pair_end && (action_i == ACT_RETRY);
    assign rd_req_o    = (st_q == ST_ISSUE);
    assign wr_req_o    = (st_q == ST_WRITE);
    assign busy_o      = (st_q != ST_IDLE);
    assign done_o      = done_q;
    assign fail_o      = fail_q;

endmodule

// File: rtl/tgl_poll_ctrl.sv
module tgl_poll_ctrl
    import tgl_poll_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  max_polls_i,
    output logic              rd_req_o,
    input  logic              rd_valid_i,
    input  logic [7:0]        rd_data_i,
    output logic              wr_req_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [7:0]        wr_data_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              fail_o
);

    action_e action;
    logic    first_tog;
    logic    confirm;
    logic    load;
    logic    inc;
    logic    limit_last;

    tgl_poll_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .rd_valid_i  (rd_valid_i),
        .rd_data_i   (rd_data_i),
        .action_i    (action),
        .first_tog_o (first_tog),
        .confirm_o   (confirm),
        .load_o      (load),
        .inc_o       (inc),
        .rd_req_o    (rd_req_o),
        .wr_req_o    (wr_req_o),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .fail_o      (fail_o)
    );

    tgl_poll_eval u_eval (
        .first_tog_i  (first_tog),
        .second_i     (rd_data_i),
        .confirm_i    (confirm),
        .limit_last_i (limit_last),
        .action_o     (action)
    );

    tgl_poll_limit #(.CNT_W(CNT_W)) u_limit (
        .clk    (clk),
        .rst    (rst),
        .load_i (load),
        .max_i  (max_polls_i),
        .inc_i  (inc),
        .last_o (limit_last)
    );

    assign wr_addr_o = '0;
    assign wr_data_o = wr_req_o ? RESET_CMD : '0;

endmodule

// File: rtl/tgl_poll_chk.sv
module tgl_poll_chk (
    input logic clk,
    input logic rst,
    input logic rd_req_o,
    input logic wr_req_o,
    input logic busy_o,
    input logic done_o,
    input logic fail_o
);

    AST_RD_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        rd_req_o |=> !rd_req_o);                                   // R2
    AST_FAIL_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        fail_o |-> $past(wr_req_o));                               // R6
    AST_WRITE_PULSE: assert property (@(posedge clk) disable iff (rst)
        wr_req_o |=> fail_o);                                      // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);                                       // R8
    AST_FAIL_PULSE: assert property (@(posedge clk) disable iff (rst)
        fail_o |=> !fail_o);                                       // R8
    AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(done_o && fail_o));                                      // R8
    AST_END_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (done_o || fail_o) |-> !busy_o);                           // R8
    AST_BUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(rd_req_o && wr_req_o));                                  // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !(rd_req_o || wr_req_o));                      // R10

endmodule

bind tgl_poll_ctrl tgl_poll_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_req_o (rd_req_o),
    .wr_req_o (wr_req_o),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .fail_o   (fail_o)
);

// File: tb/tb_tgl_poll_ctrl.sv
module tb_tgl_poll_ctrl;

    localparam int CNT_W  = 16;
    localparam int ADDR_W = 20;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_i = 1'b0;
    logic [CNT_W-1:0]  max_polls_i = '0;
    logic              rd_req_o;
    logic              rd_valid_i = 1'b0;
    logic [7:0]        rd_data_i = '0;
    logic              wr_req_o;
    logic [ADDR_W-1:0] wr_addr_o;
    logic [7:0]        wr_data_o;
    logic              busy_o;
    logic              done_o;
    logic              fail_o;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    always #10 clk = ~clk;

    tgl_poll_ctrl #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst(rst), .start_i(start_i), .max_polls_i(max_polls_i),
        .rd_req_o(rd_req_o), .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
        .wr_req_o(wr_req_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
        .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Device status model: bit 6 alternates for the first s reads then holds,
    // bit 5 sets from read f onward, bits 3:0 carry unrelated noise.
    function automatic logic [7:0] dev_stat(input int n, input int s, input int f);
        int k;
        logic [7:0] v;
        if (s == 0)     k = 0;
        else if (n < s) k = n;
        else            k = s - 1;
        v      = 8'h00;
        v[6]   = k[0];
        v[5]   = (n >= f);
        v[3:0] = n[3:0];
        return v;
    endfunction

    task automatic expect_run(input int s, input int f, input int maxp,
                              output int reads, output bit failed, output string tag);
        int  cnt;
        bit  conf;
        bit  tog;
        cnt = 0; conf = 0; failed = 0; reads = 0; tag = "R3";
        for (int k = 0; k < 100; k++) begin
            reads = 2 * k + 2;
            tog = dev_stat(2 * k, s, f)[6] != dev_stat(2 * k + 1, s, f)[6];
            if (!tog) begin
                tag = conf ? "R5" : "R3";
                break;
            end else if (conf) begin
                failed = 1; tag = "R6";
                break;
            end else if (dev_stat(2 * k + 1, s, f)[5]) begin
                conf = 1;
            end else begin
                cnt++;
                if (maxp != 0 && cnt == maxp) begin
                    failed = 1; tag = "R7";
                    break;
                end
            end
        end
    endtask

    task automatic run_op(input int s, input int f, input int maxp, input int lat);
        int    exp_reads;
        bit    exp_fail;
        string tag;
        int    nreads = 0;
        int    cd = 0;
        int    done_cnt = 0;
        int    fail_cnt = 0;
        int    wr_cnt = 0;
        int    cyc = 0;
        bit    fin = 0;
        bit    wr_ok = 1;
        bit    both = 0;
        bit    stray_done = 0;
        expect_run(s, f, maxp, exp_reads, exp_fail, tag);
        max_polls_i = CNT_W'(maxp);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o === 1'b1 && rd_req_o === 1'b1, "R2 start", int'(busy_o), 1);
        while (!fin && cyc < 2000) begin
            rd_valid_i = 1'b0;
            start_i = 1'b0;
            if (cd > 0) begin
                cd--;
                if (cd == 0) begin
                    rd_valid_i = 1'b1;
                    rd_data_i = dev_stat(nreads, s, f);
                    nreads++;
                end
            end
            if (rd_req_o) cd = lat;
            if (rd_req_o && wr_req_o) both = 1;
            if (wr_req_o) begin
                wr_cnt++;
                if (wr_data_o !== 8'hF0 || wr_addr_o !== '0) wr_ok = 0;
            end
            if (done_o) done_cnt++;
            if (fail_o) fail_cnt++;
            if (done_o || fail_o) fin = 1;
            if (nreads == 1 && !stray_done) begin
                start_i = 1'b1;       // R9: start while busy
                stray_done = 1;
            end
            cyc++;
            @(negedge clk);
        end
        rd_valid_i = 1'b0;
        start_i = 1'b0;
        check(fail_cnt == int'(exp_fail) && done_cnt == int'(!exp_fail), tag, fail_cnt, int'(exp_fail));
        check(nreads == exp_reads, "R4 read count (R9 stray start)", nreads, exp_reads);
        check(wr_cnt == int'(exp_fail) && wr_ok, "R6 reset write", wr_cnt, int'(exp_fail));
        check(!both, "R10 exclusive", int'(both), 0);
        check(!done_o && !fail_o && !busy_o, "R8 pulse", int'(done_o || fail_o), 0);
        repeat (3) begin
            @(negedge clk);
            check(!rd_req_o && !busy_o, "R9 idle after run", int'(rd_req_o), 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!busy_o && !done_o && !fail_o && !rd_req_o && !wr_req_o, "R1 in reset", int'(busy_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy_o && !done_o && !fail_o && !rd_req_o && !wr_req_o, "R1 after reset", int'(busy_o), 0);
        for (int s = 0; s < 10; s++) begin
            for (int fi = 0; fi < 5; fi++) begin
                for (int mp = 0; mp < 3; mp++) begin
                    int f;
                    int maxp;
                    f    = (fi == 0) ? 2 : (fi == 1) ? 3 : (fi == 2) ? 4 : (fi == 3) ? 7 : 100;
                    maxp = (mp == 0) ? 0 : mp + 1;
                    run_op(s, f, maxp, 1 + ((s + f + mp) % 3));
                end
            end
        end
        finish_run();
    end

endmodule